// File: doc/BRIEF.md
# Interrupt Entry Arbiter for a Cycle-Stepped 8-bit CPU

This block owns the state register of an 8-bit CPU's per-cycle sequencer and decides, at each opcode-fetch boundary, whether the next cycle continues with the normal fetch or starts an interrupt entry sequence. The state is a 16-bit code: the upper byte carries the current opcode and the lower byte the cycle index within it. The value zero means "opcode fetch". When no entry is started, the state follows the next-state value that the sequencer computes.

Three request kinds compete for entry:
- **Reset** is a sticky request and always wins.
- **Non-maskable request** is converted into a one-shot event.
- **Two maskable level sources** are OR-combined and gated by the CPU's interrupt-disable flag.

The non-maskable and maskable requests must each have been pending for a minimum number of cycles. That age is measured against a free-running cycle counter, which is captured when each request first becomes active.

A bus-available line lets another bus master stall the CPU. During a cycle that would read while the bus is taken, the state and the vector are frozen and no entry is taken. The block has no streaming data path, so there is no valid/ready interface. Every pin is a plain level control or status signal, sampled on the rising clock edge.

Top module: `irq_entry_arbiter`

## Requirements
- R1: While `rst_n` is low, `state` is 0x0000 and `vector` is 0xFFFC.
- R2: An entry is never started while `state` is non-zero; a pending request waits until `state` is 0x0000.
- R3: The priority at a fetch is reset, then non-maskable, then maskable. Reset entry gives `state` 0x0000 with `vector` 0xFFFC. Non-maskable entry gives `state` 0x0010 with `vector` 0xFFFA. Maskable entry gives `state` 0x0008 with `vector` 0xFFFE.
- R4: A non-maskable request rising at edge k may be taken no earlier than edge k+2: at least MIN_AGE (2) counter steps must have passed since its rise was seen.
- R5: Taking the non-maskable request clears it. Holding `nmi_req` high afterwards starts no further entry. A new entry needs `nmi_req` to go low and then high again.
- R6: The maskable request is `irq_a | irq_b`. It is taken only when `i_flag` is 0 and the request has been held for at least MIN_AGE counter steps since its rise.
- R7: The maskable request is level-sensitive. If it is still held, it is taken again at the next fetch. If it is dropped before it has aged, no entry is made.
- R8: `fetch_stall` equals `!ba && rd_cycle`. While it is high, `state` and `vector` keep their values and no entry is taken. With `rd_cycle` low, `ba` has no effect.
- R9: A reset entry discards a pending non-maskable request.
- R10: Without a stall or an entry, `state` takes the value of `seq_next` at each edge.
- R11: Request age is computed modulo 2^CNT_W, so a request that rises just before the cycle counter wraps still becomes eligible after MIN_AGE steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reset_req | input | 1 | Reset entry request, latched until taken |
| nmi_req | input | 1 | Non-maskable request, rising edge significant |
| irq_a | input | 1 | Maskable request source A, level |
| irq_b | input | 1 | Maskable request source B, level |
| i_flag | input | 1 | Interrupt-disable flag of the CPU |
| cycle_cnt | input | CNT_W | Free-running cycle counter |
| ba | input | 1 | Bus available; low means another master holds the bus |
| rd_cycle | input | 1 | Current cycle performs a read |
| seq_next | input | 16 | Next state computed by the sequencer |
| state | output | 16 | Current sequencer state (opcode byte, cycle byte) |
| vector | output | 16 | Vector address of the most recent entry |
| fetch_stall | output | 1 | Current cycle is stalled by the bus |

## Verification
The bench targets the following corner cases:
- **Age window.** The bench sweeps the rise of each request relative to the fetch edges, including counter values either side of the wrap. An off-by-one in the age compare enters one cycle early or late. A non-modular compare never enters near the wrap.
- **Held non-maskable input.** A design that treats this input as a level re-enters on every fetch.
- **Maskable sources.** The bench tries every combination of the two sources against `i_flag`. It also drops a source before it has aged, where a latched design would wrongly enter.
- **Simultaneous requests.** With several requests at once, an inverted priority picks the wrong vector, and a reset that fails to discard the non-maskable request enters it after the reset.
- **Bus stall.** A stalled fetch with an aged request shows whether the state leaks forward under the stall.

// File: rtl/iea_pkg.sv
package iea_pkg;
  localparam int STATE_W = 16;
  localparam int VEC_W   = 16;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_RESET = 2'd1,
    SRC_NMI   = 2'd2,
    SRC_IRQ   = 2'd3
  } entry_src_e;
endpackage

// File: rtl/iea_req_tracker.sv
module iea_req_tracker #(
  parameter int CNT_W     = 16,
  parameter int MIN_AGE   = 2,
  parameter bit EDGE_MODE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             take_i,
  input  logic             flush_i,
  output logic             ready_o
);
  localparam logic [CNT_W-1:0] AGE_LIM = CNT_W'(MIN_AGE);

  logic             prev_q;
  logic             pend_q;
  logic [CNT_W-1:0] t0_q;
  logic [CNT_W-1:0] age;
  logic             rise;

  assign rise = req_i & ~prev_q;
  assign age  = cnt_i - t0_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= req_i;
  end

  generate
    if (EDGE_MODE) begin : g_edge
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pend_q <= 1'b0;
          t0_q   <= '0;
        end else if (take_i || flush_i) begin
          pend_q <= rise;
          if (rise) t0_q <= cnt_i;
        end else if (rise && !pend_q) begin
          pend_q <= 1'b1;
          t0_q   <= cnt_i;
        end
      end
      assign ready_o = pend_q && (age >= AGE_LIM);
    end else begin : g_level
      logic unused_take;
      assign unused_take = take_i;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pend_q <= 1'b0;
          t0_q   <= '0;
        end else begin
          pend_q <= req_i & ~flush_i;
          if (rise) t0_q <= cnt_i;
        end
      end
      assign ready_o = req_i && pend_q && (age >= AGE_LIM);
    end
  endgenerate
endmodule

// File: rtl/iea_priority.sv
module iea_priority
  import iea_pkg::*;
(
  input  logic       at_fetch,
  input  logic       stall,
  input  logic       i_flag,
  input  logic       rst_pend,
  input  logic       nmi_rdy,
  input  logic       irq_rdy,
  output entry_src_e src
);
  always_comb begin
    src = SRC_NONE;
    if (at_fetch && !stall) begin
      if (rst_pend)               src = SRC_RESET;
      else if (nmi_rdy)           src = SRC_NMI;
      else if (irq_rdy && !i_flag) src = SRC_IRQ;
    end
  end
endmodule

// File: rtl/irq_entry_arbiter.sv
module irq_entry_arbiter
  import iea_pkg::*;
#(
  parameter int             CNT_W     = 16,
  parameter int             MIN_AGE   = 2,
  parameter logic [15:0]    VEC_RESET = 16'hFFFC,
  parameter logic [15:0]    VEC_NMI   = 16'hFFFA,
  parameter logic [15:0]    VEC_IRQ   = 16'hFFFE,
  parameter logic [15:0]    ST_NMI    = 16'h0010,
  parameter logic [15:0]    ST_IRQ    = 16'h0008
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reset_req,
  input  logic             nmi_req,
  input  logic             irq_a,
  input  logic             irq_b,
  input  logic             i_flag,
  input  logic [CNT_W-1:0] cycle_cnt,
  input  logic             ba,
  input  logic             rd_cycle,
  input  logic [15:0]      seq_next,
  output logic [15:0]      state,
  output logic [15:0]      vector,
  output logic             fetch_stall
);
  localparam logic [STATE_W-1:0] ST_FETCH = '0;

  logic [STATE_W-1:0] state_q;
  logic [VEC_W-1:0]   vec_q;
  logic               rst_pend_q;
  logic               stall;
  logic               at_fetch;
  logic               nmi_ready;
  logic               irq_ready;
  entry_src_e         src_sel;

  assign stall    = ~ba & rd_cycle;
  assign at_fetch = (state_q == ST_FETCH);

  iea_req_tracker #(.CNT_W(CNT_W), .MIN_AGE(MIN_AGE), .EDGE_MODE(1'b1)) u_nmi (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (nmi_req),
    .cnt_i  (cycle_cnt),
    .take_i (src_sel == SRC_NMI),
    .flush_i(src_sel == SRC_RESET),
    .ready_o(nmi_ready)
  );

  iea_req_tracker #(.CNT_W(CNT_W), .MIN_AGE(MIN_AGE), .EDGE_MODE(1'b0)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (irq_a | irq_b),
    .cnt_i  (cycle_cnt),
    .take_i (src_sel == SRC_IRQ),
    .flush_i(1'b0),
    .ready_o(irq_ready)
  );

  iea_priority u_prio (
    .at_fetch(at_fetch),
    .stall   (stall),
    .i_flag  (i_flag),
    .rst_pend(rst_pend_q),
    .nmi_rdy (nmi_ready),
    .irq_rdy (irq_ready),
    .src     (src_sel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rst_pend_q <= 1'b0;
    else        rst_pend_q <= (rst_pend_q & (src_sel != SRC_RESET)) | reset_req;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      vec_q   <= VEC_RESET;
    end else if (!stall) begin
      unique case (src_sel)
        SRC_RESET: begin state_q <= ST_FETCH; vec_q <= VEC_RESET; end
        SRC_NMI:   begin state_q <= ST_NMI;   vec_q <= VEC_NMI;   end
        SRC_IRQ:   begin state_q <= ST_IRQ;   vec_q <= VEC_IRQ;   end
        default:   state_q <= seq_next;
      endcase
    end
  end

  assign state       = state_q;
  assign vector      = vec_q;
  assign fetch_stall = stall;
endmodule

// File: rtl/irq_entry_checker.sv
module irq_entry_checker #(
  parameter logic [15:0] VEC_RESET = 16'hFFFC,
  parameter logic [15:0] VEC_NMI   = 16'hFFFA,
  parameter logic [15:0] ST_NMI    = 16'h0010
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] state,
  input logic [15:0] vector,
  input logic [15:0] seq_next,
  input logic        stall,
  input logic        i_flag,
  input logic        rst_pend,
  input logic        nmi_ready,
  input logic [1:0]  src
);
  assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (state == $past(state)) && (vector == $past(vector)));

  assert_follow_seq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && state != 16'h0000) |=> state == $past(seq_next));

  assert_reset_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && state == 16'h0000 && rst_pend) |=>
      (state == 16'h0000 && vector == VEC_RESET && !nmi_ready));

  assert_nmi_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && state == 16'h0000 && !rst_pend && nmi_ready) |=>
      (state == ST_NMI && vector == VEC_NMI));

  assert_nmi_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (src == 2'd2) |=> !nmi_ready);

  assert_irq_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && state == 16'h0000 && i_flag && !rst_pend && !nmi_ready) |=>
      state == $past(seq_next));
endmodule

bind irq_entry_arbiter irq_entry_checker #(
  .VEC_RESET(VEC_RESET), .VEC_NMI(VEC_NMI), .ST_NMI(ST_NMI)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .state    (state),
  .vector   (vector),
  .seq_next (seq_next),
  .stall    (stall),
  .i_flag   (i_flag),
  .rst_pend (rst_pend_q),
  .nmi_ready(nmi_ready),
  .src      (src_sel)
);

// File: tb/test_irq_entry_arbiter.sv
`timescale 1ns/1ps
module test_irq_entry_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reset_req = 1'b0, nmi_req = 1'b0, irq_a = 1'b0, irq_b = 1'b0;
  logic        i_flag = 1'b0, ba = 1'b1, rd_cycle = 1'b1;
  logic [15:0] cycle_cnt = 16'h0000;
  logic [15:0] seq_next = 16'h0000;
  logic [15:0] state, vector;
  logic        fetch_stall;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  irq_entry_arbiter i_irq_entry_arbiter (
    .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .nmi_req(nmi_req),
    .irq_a(irq_a), .irq_b(irq_b), .i_flag(i_flag), .cycle_cnt(cycle_cnt),
    .ba(ba), .rd_cycle(rd_cycle), .seq_next(seq_next),
    .state(state), .vector(vector), .fetch_stall(fetch_stall)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cycle_cnt = cycle_cnt + 16'd1;
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(); step();
    chk("R1 state", state, 16'h0000);
    chk("R1 vector", vector, 16'hFFFC);
    rst_n = 1'b1;
    ba = 1'b0; #0.1;
    chk("R8 stall flag", {15'd0, fetch_stall}, 16'd1);
    rd_cycle = 1'b0; #0.1;
    chk("R8 no read", {15'd0, fetch_stall}, 16'd0);
    ba = 1'b1; rd_cycle = 1'b1;

    // R10: follow sequencer
    seq_next = 16'h0105; step(); chk("R10 a", state, 16'h0105);
    seq_next = 16'h0106; step(); chk("R10 b", state, 16'h0106);
    seq_next = 16'h0000; step(); chk("R10 c", state, 16'h0000);

    // R4: age window
    nmi_req = 1'b1;
    step(); chk("R4 age0", state, 16'h0000);
    step(); chk("R4 age1", state, 16'h0000);
    step(); chk("R4 enter", state, 16'h0010); chk("R3 nmi vec", vector, 16'hFFFA);
    step(); chk("R10 return", state, 16'h0000);
    // R5: held input does not re-enter
    for (int i = 0; i < 4; i++) begin step(); chk("R5 held", state, 16'h0000); end
    nmi_req = 1'b0; step();
    nmi_req = 1'b1; step(); step(); chk("R5 re-arm wait", state, 16'h0000);
    step(); chk("R5 re-arm enter", state, 16'h0010);
    step(); nmi_req = 1'b0; step();

    // R11: counter wrap sweep
    for (int k = 0; k < 4; k++) begin
      cycle_cnt = 16'hFFFD + 16'(k);
      nmi_req = 1'b1;
      step(); step(); chk("R11 early", state, 16'h0000);
      step(); chk("R11 enter", state, 16'h0010);
      step(); nmi_req = 1'b0; step();
    end

    // R2: no entry outside fetch
    seq_next = 16'h0203; step();
    nmi_req = 1'b1;
    for (int i = 0; i < 4; i++) begin step(); chk("R2 wait", state, 16'h0203); end
    seq_next = 16'h0000; step(); chk("R2 fetch", state, 16'h0000);
    step(); chk("R2 enter", state, 16'h0010);
    step(); nmi_req = 1'b0; step();

    // R8: stall at fetch with aged request
    ba = 1'b0; seq_next = 16'h0300; nmi_req = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step(); chk("R8 hold", state, 16'h0000);
      chk("R8 flag", {15'd0, fetch_stall}, 16'd1);
    end
    rd_cycle = 1'b0; step(); chk("R8 non-read enters", state, 16'h0010);
    rd_cycle = 1'b1; ba = 1'b1; seq_next = 16'h0000; step();
    nmi_req = 1'b0; step();

    // R6: all source combinations
    for (int c = 0; c < 4; c++) begin
      irq_a = c[0]; irq_b = c[1];
      step(); step(); step();
      chk("R6 combo", state, (c != 0) ? 16'h0008 : 16'h0000);
      if (c != 0) chk("R3 irq vec", vector, 16'hFFFE);
      irq_a = 1'b0; irq_b = 1'b0; step(); step();
    end

    // R6 mask and R7 level re-entry
    i_flag = 1'b1; irq_a = 1'b1;
    for (int i = 0; i < 5; i++) begin step(); chk("R6 masked", state, 16'h0000); end
    i_flag = 1'b0; step(); chk("R6 unmask", state, 16'h0008);
    step(); chk("R7 back", state, 16'h0000);
    step(); chk("R7 re-enter", state, 16'h0008);
    irq_a = 1'b0; step(); step(); chk("R7 released", state, 16'h0000);
    // R7 dropped before aging
    irq_b = 1'b1; step(); irq_b = 1'b0;
    for (int i = 0; i < 3; i++) begin step(); chk("R7 short pulse", state, 16'h0000); end

    // R3: NMI over IRQ
    nmi_req = 1'b1; irq_a = 1'b1;
    step(); step(); step();
    chk("R3 nmi first", state, 16'h0010); chk("R3 nmi first vec", vector, 16'hFFFA);
    step(); chk("R3 back", state, 16'h0000);
    step(); chk("R3 irq next", state, 16'h0008);
    nmi_req = 1'b0; irq_a = 1'b0; step(); step();

    // R3/R9: reset wins and discards NMI
    seq_next = 16'h0203; step();
    reset_req = 1'b1; nmi_req = 1'b1; irq_a = 1'b1; step();
    reset_req = 1'b0; step(); step();
    chk("R2 busy", state, 16'h0203);
    seq_next = 16'h0000; step(); chk("R9 fetch", state, 16'h0000);
    step(); chk("R9 reset state", state, 16'h0000); chk("R3 reset vec", vector, 16'hFFFC);
    step(); chk("R9 nmi discarded", state, 16'h0008); chk("R9 irq vec", vector, 16'hFFFE);
    nmi_req = 1'b0; irq_a = 1'b0; step(); step();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule